// File: doc/BRIEF.md
# Dual-Side Integration Sequencer

This controller runs the front end of a converter that has two integrators, side A and side B, which take turns on one input. The host drives a single level input, `conv`. Each change of that level hands integration from one side to the other. When a side finishes integrating, the controller times a measure, reset and auto-zero interval for it, counted in clock periods. While that interval runs, a busy flag is held high. The controller lowers an active-low data-valid output when a result is ready, and names on a one-bit tag which side the result belongs to. The flag stays low until the host pulls the active-low transmit strobe.

An eight-state machine sequences the work. Four states form a continuous mode: one side always integrates and the handover costs no time. The other four states form a non-continuous mode: the input is idle while a measurement is pending, and the controller then prepares the correct side for the next integration. The busy flag decides which path a `conv` edge takes. The states come in mirrored pairs, selected by the level of `conv`. Because of this pairing, integrations always alternate between A and B, whatever pattern the host applies.

Top module: `dual_integ_seq`

## Requirements
- R1: During and after a synchronous reset, `state_num` is 1 if the synchronized `conv` is high and 8 if it is low. `int_active` is 0, `meas_busy` is 0 and `dvalid_n` is 1.
- R2: In state 1 (or 8) with busy low, the next state is 2 (or 7) when `conv` is high (or low). In state 2 or 7, a `conv` edge moves to state 3 (`conv` low) or state 6 (`conv` high), and integration starts (`int_active`=1).
- R3: In states 3 to 6, a `conv` edge taken with busy low moves to state 4 when `conv` is now high and to state 5 when it is now low. The side that stopped integrating starts a continuous measure cycle. `int_active` is 1 exactly in states 3 to 6.
- R4: In state 4 or 5, a `conv` edge taken while busy is high stops integration. The state becomes 1 (`conv` high) or 8 (`conv` low). States 1 and 8 hold, following the `conv` level, for as long as busy is high.
- R5: `int_side` (0 = side A, 1 = side B) gives the integrating side, or the next side to integrate when idle. The first integration after reset uses A, and each later integration uses the opposite side of the one before it.
- R6: A continuous measure cycle holds `meas_busy` high for exactly CM_LEN clocks from its start edge. `dvalid_n` falls CM_RDY clocks after that edge, with `data_side` equal to the side whose integration ended.
- R7: A non-continuous cycle (entered per R4) holds busy for NC_LEN clocks. It reports twice: at NC_RDY1 clocks, tagged with the side measured before the cycle began, and at NC_RDY2 clocks, tagged with the side whose integration was just stopped.
- R8: Once low, `dvalid_n` stays low until `xmit_n` is sampled low. It is then high on the next clock. A ready event in the same clock wins. `xmit_n` has no effect while no data is pending.
- R9: `conv` passes through a SYNC_STAGES-flop synchronizer. A level change on `conv` moves the state SYNC_STAGES+1 clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv | input | 1 | Host integration-select level, asynchronous |
| xmit_n | input | 1 | Host transmit strobe, active low |
| dvalid_n | output | 1 | Result ready, active low |
| data_side | output | 1 | Side of the pending result (0 = A, 1 = B) |
| int_side | output | 1 | Integrating side, or next side when idle |
| int_active | output | 1 | A side is integrating |
| meas_busy | output | 1 | Measure/reset/auto-zero interval in progress |
| state_num | output | 4 | Current state number, 1 to 8 |

## Verification
The bench shortens the timing parameters to CM_LEN=40, CM_RDY=30, NC_LEN=80, NC_RDY1=30 and NC_RDY2=50, and keeps two synchronizer stages. With these values, a `conv` toggle can be placed well inside a running measure cycle or well after it. This reaches both the busy path into states 1/8 and the continuous handover between states 4 and 5. The same values let both ready points of a non-continuous cycle, the full busy windows and the mirrored start from a low `conv` be checked to the exact clock.

// File: rtl/dis_pkg.sv
package dis_pkg;
   // state codes are the state numbers 1..8
   typedef enum logic [3:0] {
      ST_HOLD_H  = 4'd1,
      ST_PREP_H  = 4'd2,
      ST_FIRST_L = 4'd3,
      ST_RUN_H   = 4'd4,
      ST_RUN_L   = 4'd5,
      ST_FIRST_H = 4'd6,
      ST_PREP_L  = 4'd7,
      ST_HOLD_L  = 4'd8
   } seq_state_t;
endpackage

// File: rtl/dis_sync.sv
module dis_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dis_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dis_mrz_timer.sv
module dis_mrz_timer #(
   parameter int CM_LEN  = 4794,
   parameter int CM_RDY  = 4212,
   parameter int NC_LEN  = 9108,
   parameter int NC_RDY1 = 4212,
   parameter int NC_RDY2 = 4548,
   localparam int CW = $clog2(NC_LEN + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic start_cm,
   input  logic start_nc,
   input  logic side_end,
   output logic busy,
   output logic rdy,
   output logic rdy_side
);
   localparam logic [CW-1:0] K_CM_LAST = CW'(CM_LEN - 1);
   localparam logic [CW-1:0] K_NC_LAST = CW'(NC_LEN - 1);
   localparam logic [CW-1:0] K_CM_RDY  = CW'(CM_RDY - 1);
   localparam logic [CW-1:0] K_NC_RDY1 = CW'(NC_RDY1 - 1);
   localparam logic [CW-1:0] K_NC_RDY2 = CW'(NC_RDY2 - 1);

   logic [CW-1:0] cnt;
   logic          run, nc_mode, tag1, tag2;
   logic [CW-1:0] last;

   assign last = nc_mode ? K_NC_LAST : K_CM_LAST;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt     <= '0;
         run     <= 1'b0;
         nc_mode <= 1'b0;
         tag1    <= 1'b0;
         tag2    <= 1'b0;
      end else if (start_cm) begin
         cnt     <= '0;
         run     <= 1'b1;
         nc_mode <= 1'b0;
         tag1    <= side_end;
      end else if (start_nc) begin
         cnt     <= '0;
         run     <= 1'b1;
         nc_mode <= 1'b1;
         tag1    <= ~side_end;
         tag2    <= side_end;
      end else if (run) begin
         if (cnt == last) run <= 1'b0;
         else             cnt <= cnt + 1'b1;
      end
   end

   assign busy     = run;
   assign rdy      = run && (nc_mode ? (cnt == K_NC_RDY1 || cnt == K_NC_RDY2)
                                     : (cnt == K_CM_RDY));
   assign rdy_side = (nc_mode && cnt == K_NC_RDY2) ? tag2 : tag1;
endmodule

// File: rtl/dual_integ_seq.sv
module dual_integ_seq
   import dis_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CM_LEN      = 4794,
   parameter int CM_RDY      = 4212,
   parameter int NC_LEN      = 9108,
   parameter int NC_RDY1     = 4212,
   parameter int NC_RDY2     = 4548
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       conv,
   input  logic       xmit_n,
   output logic       dvalid_n,
   output logic       data_side,
   output logic       int_side,
   output logic       int_active,
   output logic       meas_busy,
   output logic [3:0] state_num
);
   generate
      if (CM_RDY < 1 || CM_RDY >= CM_LEN) begin : g_bad_cm
         $error("dual_integ_seq: CM_RDY must lie inside the continuous cycle");
      end
      if (NC_RDY1 < 1 || NC_RDY2 <= NC_RDY1 || NC_RDY2 >= NC_LEN) begin : g_bad_nc
         $error("dual_integ_seq: non-continuous ready points out of order");
      end
   endgenerate

   seq_state_t state;
   logic conv_s, conv_d, conv_edge;
   logic side, active;
   logic start_cm, start_nc, busy, rdy_pulse, rdy_side;
   logic run_st, first_st;

   dis_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk (clk),
      .d   (conv),
      .q   (conv_s)
   );

   dis_mrz_timer #(
      .CM_LEN(CM_LEN), .CM_RDY(CM_RDY),
      .NC_LEN(NC_LEN), .NC_RDY1(NC_RDY1), .NC_RDY2(NC_RDY2)
   ) i_timer (
      .clk      (clk),
      .rst      (rst),
      .start_cm (start_cm),
      .start_nc (start_nc),
      .side_end (side),
      .busy     (busy),
      .rdy      (rdy_pulse),
      .rdy_side (rdy_side)
   );

   assign conv_edge = conv_s ^ conv_d;
   assign run_st    = (state == ST_RUN_H) || (state == ST_RUN_L);
   assign first_st  = (state == ST_FIRST_H) || (state == ST_FIRST_L);
   assign start_cm  = conv_edge && (first_st || (run_st && !busy));
   assign start_nc  = conv_edge && run_st && busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= conv_s ? ST_HOLD_H : ST_HOLD_L;
         conv_d <= conv_s;
         side   <= 1'b0;
         active <= 1'b0;
      end else begin
         conv_d <= conv_s;
         unique case (state)
            ST_HOLD_H, ST_HOLD_L: begin
               if (busy) state <= conv_s ? ST_HOLD_H : ST_HOLD_L;
               else      state <= conv_s ? ST_PREP_H : ST_PREP_L;
            end
            ST_PREP_H, ST_PREP_L: begin
               if (conv_edge) begin
                  state  <= conv_s ? ST_FIRST_H : ST_FIRST_L;
                  active <= 1'b1;
               end
            end
            ST_FIRST_L, ST_RUN_H, ST_RUN_L, ST_FIRST_H: begin
               if (conv_edge) begin
                  side <= ~side;
                  if (start_nc) begin
                     state  <= conv_s ? ST_HOLD_H : ST_HOLD_L;
                     active <= 1'b0;
                  end else begin
                     state <= conv_s ? ST_RUN_H : ST_RUN_L;
                  end
               end
            end
            default: state <= ST_HOLD_L;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dvalid_n  <= 1'b1;
         data_side <= 1'b0;
      end else if (rdy_pulse) begin
         dvalid_n  <= 1'b0;
         data_side <= rdy_side;
      end else if (!xmit_n) begin
         dvalid_n  <= 1'b1;
      end
   end

   assign int_side   = side;
   assign int_active = active;
   assign meas_busy  = busy;
   assign state_num  = 4'(state);
endmodule

// File: rtl/dis_checker.sv
module dis_checker (
   input logic       clk,
   input logic       rst,
   input logic       xmit_n,
   input logic       dvalid_n,
   input logic       int_side,
   input logic       int_active,
   input logic       meas_busy,
   input logic [3:0] state_num,
   input logic       rdy
);
   // R1
   state_range_chk: assert property (@(posedge clk) disable iff (rst)
      state_num >= 4'd1 && state_num <= 4'd8);

   // R3
   active_states_chk: assert property (@(posedge clk) disable iff (rst)
      (state_num >= 4'd3 && state_num <= 4'd6) == int_active);

   // R4
   hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
      ((state_num == 4'd1 || state_num == 4'd8) && meas_busy)
      |=> (state_num == 4'd1 || state_num == 4'd8));

   // R5
   side_flip_chk: assert property (@(posedge clk) disable iff (rst)
      (int_active && $past(int_active) && state_num != $past(state_num))
      |-> int_side != $past(int_side));

   // R6
   ready_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
      rdy |=> !dvalid_n);

   // R8
   flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (!dvalid_n && xmit_n) |=> !dvalid_n);

   // R8
   flag_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (!xmit_n && !rdy) |=> dvalid_n);
endmodule

bind dual_integ_seq dis_checker i_chk (
   .clk        (clk),
   .rst        (rst),
   .xmit_n     (xmit_n),
   .dvalid_n   (dvalid_n),
   .int_side   (int_side),
   .int_active (int_active),
   .meas_busy  (meas_busy),
   .state_num  (state_num),
   .rdy        (rdy_pulse)
);

// File: tb/test_dual_integ_seq.sv
module test_dual_integ_seq;
   localparam int CM_LEN = 40, CM_RDY = 30, NC_LEN = 80, NC_RDY1 = 30, NC_RDY2 = 50;

   logic clk = 1'b0, rst = 1'b1, conv = 1'b1, xmit_n = 1'b1;
   logic dvalid_n, data_side, int_side, int_active, meas_busy;
   logic [3:0] state_num;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dual_integ_seq #(
      .SYNC_STAGES(2), .CM_LEN(CM_LEN), .CM_RDY(CM_RDY),
      .NC_LEN(NC_LEN), .NC_RDY1(NC_RDY1), .NC_RDY2(NC_RDY2)
   ) i_dual_integ_seq (
      .clk(clk), .rst(rst), .conv(conv), .xmit_n(xmit_n),
      .dvalid_n(dvalid_n), .data_side(data_side), .int_side(int_side),
      .int_active(int_active), .meas_busy(meas_busy), .state_num(state_num)
   );

   // {conv, wait cycles[7:0], state[3:0], active, side}
   localparam logic [14:0] VEC [0:8] = '{
      {1'b0, 8'd6,  4'd3, 1'b1, 1'b0},
      {1'b1, 8'd50, 4'd4, 1'b1, 1'b1},
      {1'b0, 8'd50, 4'd5, 1'b1, 1'b0},
      {1'b1, 8'd6,  4'd4, 1'b1, 1'b1},
      {1'b0, 8'd6,  4'd8, 1'b0, 1'b0},
      {1'b1, 8'd6,  4'd1, 1'b0, 1'b0},
      {1'b1, 8'd90, 4'd2, 1'b0, 1'b0},
      {1'b0, 8'd6,  4'd3, 1'b1, 1'b0},
      {1'b1, 8'd50, 4'd4, 1'b1, 1'b1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic lvl);
      rst = 1'b1; conv = lvl; xmit_n = 1'b1;
      tick(5);
      rst = 1'b0;
   endtask

   task automatic wait_change();
      logic [3:0] old;
      old = state_num;
      for (int k = 0; k < 20; k++) begin
         tick(1);
         if (state_num != old) break;
      end
   endtask

   task automatic strobe();
      xmit_n = 1'b0; tick(1); xmit_n = 1'b1;
   endtask

   initial begin
      @(negedge clk);
      // table walk
      do_reset(1'b1);
      chk("R1 start high state", state_num, 1);
      tick(2);
      chk("R2 prep state", state_num, 2);
      for (int i = 0; i < 9; i++) begin
         conv = VEC[i][14];
         tick(int'(VEC[i][13:6]));
         chk($sformatf("R3 R4 row %0d state", i), state_num, int'(VEC[i][5:2]));
         chk($sformatf("R3 row %0d active", i), int_active, int'(VEC[i][1]));
         chk($sformatf("R5 row %0d side", i), int_side, int'(VEC[i][0]));
      end

      // reset state and handshake timing
      do_reset(1'b1);
      chk("R1 state", state_num, 1);
      chk("R1 busy", meas_busy, 0);
      chk("R1 dvalid", dvalid_n, 1);
      chk("R1 active", int_active, 0);
      tick(2);
      chk("R2 state 2", state_num, 2);
      strobe();
      chk("R8 strobe without data", dvalid_n, 1);
      conv = 1'b0;
      tick(1); tick(1);
      chk("R9 no move after two edges", state_num, 2);
      tick(1);
      chk("R9 move on third edge", state_num, 3);
      chk("R5 first side A", int_side, 0);
      conv = 1'b1; wait_change();
      chk("R3 state 4", state_num, 4);
      tick(CM_RDY - 1);
      chk("R6 not ready early", dvalid_n, 1);
      tick(1);
      chk("R6 ready", dvalid_n, 0);
      chk("R6 tag A", data_side, 0);
      tick(CM_LEN - CM_RDY - 1);
      chk("R6 busy last clock", meas_busy, 1);
      tick(1);
      chk("R6 busy ends", meas_busy, 0);
      chk("R8 held low", dvalid_n, 0);
      strobe();
      chk("R8 cleared", dvalid_n, 1);

      // non-continuous cycle
      conv = 1'b0; wait_change();
      chk("R3 state 5", state_num, 5);
      chk("R5 side A again", int_side, 0);
      conv = 1'b1; wait_change();
      chk("R4 state 1", state_num, 1);
      chk("R4 stopped", int_active, 0);
      tick(NC_RDY1 - 1);
      chk("R7 first not early", dvalid_n, 1);
      tick(1);
      chk("R7 first ready", dvalid_n, 0);
      chk("R7 first tag B", data_side, 1);
      strobe();
      tick(NC_RDY2 - NC_RDY1 - 2);
      chk("R7 second not early", dvalid_n, 1);
      tick(1);
      chk("R7 second ready", dvalid_n, 0);
      chk("R7 second tag A", data_side, 0);
      tick(NC_LEN - NC_RDY2 - 1);
      chk("R7 busy last clock", meas_busy, 1);
      chk("R4 still held", state_num, 1);
      tick(1);
      chk("R7 busy ends", meas_busy, 0);
      tick(1);
      chk("R2 prep after busy", state_num, 2);
      chk("R5 next side B", int_side, 1);

      // mirrored start
      do_reset(1'b0);
      chk("R1 start low state", state_num, 8);
      tick(2);
      chk("R2 state 7", state_num, 7);
      conv = 1'b1; wait_change();
      chk("R2 state 6", state_num, 6);
      chk("R5 mirror side A", int_side, 0);
      conv = 1'b0; wait_change();
      chk("R3 state 5 mirror", state_num, 5);
      chk("R5 mirror side B", int_side, 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule